// File: doc/BRIEF.md
# Flux-interval bitcell recovery PLL

This block turns a stream of flux-transition intervals, measured in sample ticks, into a serial stream of recovered bitcells. The ticks from each interval collect in a signed residual. When the residual reaches half of the current bitcell period, the block emits a burst of bitcells, one per cycle. The burst is a run of 0 cells closed by a single 1 cell. After each 1 cell a digital loop retunes the period and pulls in the phase.

A second input delivers index intervals, also in ticks. Each one loads a revolution countdown. Every bitcell lowers that countdown by one period before the cell is issued. When the countdown goes negative the block issues a one-cycle revolution-end strobe and loads the next index interval. After the revolution whose index interval carried the last marker has run out, the block stops for good.

All arithmetic is in fixed point with `FRAC` fractional bits (8 by default). The nominal period is `2*SAMPLE_MHZ` ticks, so with the default of 24 it is 48 ticks, written 12288 in fixed point.

Top module: `flux_bitcell_pll`

## Requirements
- R1: Reset sets the period to nominal and clears the residual. While reset is held and until the first index interval is taken, `idx_ready_o` is 1 and both `flux_ready_o` and `bit_valid_o` are 0. `flux_ready_o` and `idx_ready_o` are never 1 together.
- R2: An accepted interval adds `ticks<<FRAC` to the residual. No bitcell is issued while the residual is below `period>>1`.
- R3: Once the threshold is met, cells are issued one per cycle, and each one subtracts the period from the residual. A cell is 0 (`bit_o`=0) while the remainder is still at least `period>>1`. The first cell that leaves less than that is a 1 and ends the burst. `flux_ready_o` is 0 throughout the burst.
- R4: A 0 cell reports `dur_o` equal to the current period, in fixed point.
- R5: If at most 3 zeros came before the 1, the new period is `period + S(rem)`. Here `rem` is the signed remainder and `S(v)=(v>>>5)+(v>>>6)+(v>>>8)`.
- R6: If more than 3 zeros came before the 1, the new period is `period + S(NOM-period)`.
- R7: After every update the period is clamped to `[NOM-NOM/10, NOM+NOM/10]`, using integer division in fixed point. With the defaults this is [11060, 13516].
- R8: After a 1 cell the residual becomes `P(rem)`, where `P(v)=(v>>>2)+(v>>>3)+(v>>>6)+(v>>>7)`. The 1 cell reports `dur_o = period_old + rem - P(rem)`.
- R9: Before each cell the countdown drops by one period. If it goes negative, the block issues one cycle with `rev_end_o`=1 and no bit, and then takes the next index interval. The new interval replaces the countdown, and the held cell is then issued without a further decrement.
- R10: If the revolution that ends was loaded with `idx_last_i`=1, then after its `rev_end_o` no more cells are issued and `flux_ready_o` stays 0 until reset.
- R11: `rev_end_o` and `bit_valid_o` are never 1 in the same cycle. The cycle after a 1 cell carries no cell, and the cycle after `rev_end_o` carries neither a cell nor a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flux_valid_i | input | 1 | Flux interval offered |
| flux_ready_o | output | 1 | Flux interval accepted this cycle if valid |
| flux_ticks_i | input | FLUX_W | Interval between transitions, ticks |
| idx_valid_i | input | 1 | Index interval offered |
| idx_ready_o | output | 1 | Index interval accepted this cycle if valid |
| idx_ticks_i | input | IDX_W | Revolution length, ticks |
| idx_last_i | input | 1 | This index interval is the final one |
| bit_valid_o | output | 1 | A bitcell is presented |
| bit_o | output | 1 | Bitcell value |
| rev_end_o | output | 1 | Revolution boundary strobe (no bit) |
| dur_o | output | FLUX_W+FRAC+2 | Bitcell duration, fixed point ticks |

## Verification
The bench goes after several corner cases, each of which would break in a visible way if the design got it wrong.
- **Half-period threshold.** The residual is fed in sub-threshold steps until it lands exactly on half a period. Using `>` in place of `>=` would hold back the only cell, and firing too early would emit cells from the first fragments.
- **Long gaps.** These force more than three zeros. Using the wrong correction branch would give durations on later 1 cells that differ from the model.
- **Sustained early and late intervals.** These drive the period into both clamp limits. A missing or off-by-one clamp shows up as a 0-cell duration away from 11060 or 13516.
- **Short revolutions.** These check the strobe, the reload that replaces the countdown, and the final stop. A design that decremented the countdown twice, or kept running after the last revolution, would change the count of cells or of strobes.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [1:0] {
    ST_IDX  = 2'd0,
    ST_ACC  = 2'd1,
    ST_EMIT = 2'd2,
    ST_DONE = 2'd3
  } fbp_state_e;
endpackage

// File: rtl/fbp_period_adj.sv
// Period update: in-sync or relax-to-nominal step of ~5%, then clamp.
module fbp_period_adj #(
  parameter int W         = 26,
  parameter int NOM_TICKS = 48,
  parameter int FRAC      = 8
) (
  input  logic signed [W-1:0] per_i,
  input  logic signed [W-1:0] rem_i,
  input  logic                oos_i,
  output logic signed [W-1:0] per_o
);
  localparam longint NOMQ = longint'(NOM_TICKS) << FRAC;
  localparam longint LIMQ = NOMQ / 10;
  localparam logic signed [W-1:0] NOM_S = W'(NOMQ);
  localparam logic signed [W:0]   MIN_S = (W+1)'(NOMQ - LIMQ);
  localparam logic signed [W:0]   MAX_S = (W+1)'(NOMQ + LIMQ);

  logic signed [W-1:0] err, step;
  logic signed [W:0]   sum;

  always_comb begin
    err  = oos_i ? (NOM_S - per_i) : rem_i;
    step = (err >>> 5) + (err >>> 6) + (err >>> 8);
    sum  = (W+1)'(per_i) + (W+1)'(step);
    if (sum < MIN_S)      per_o = W'(MIN_S);
    else if (sum > MAX_S) per_o = W'(MAX_S);
    else                  per_o = W'(sum);
  end
endmodule

// File: rtl/fbp_phase_trim.sv
// Keeps ~40% of the residual; reports the removed part.
module fbp_phase_trim #(
  parameter int W = 26
) (
  input  logic signed [W-1:0] rem_i,
  output logic signed [W-1:0] keep_o,
  output logic signed [W-1:0] cut_o
);
  always_comb begin
    keep_o = (rem_i >>> 2) + (rem_i >>> 3) + (rem_i >>> 6) + (rem_i >>> 7);
    cut_o  = rem_i - keep_o;
  end
endmodule

// File: rtl/flux_bitcell_pll.sv
module flux_bitcell_pll
  import fbp_pkg::*;
#(
  parameter int SAMPLE_MHZ = 24,
  parameter int FRAC       = 8,
  parameter int FLUX_W     = 16,
  parameter int IDX_W      = 24,
  parameter int SYNC_ZEROS = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flux_valid_i,
  output logic                     flux_ready_o,
  input  logic [FLUX_W-1:0]        flux_ticks_i,
  input  logic                     idx_valid_i,
  output logic                     idx_ready_o,
  input  logic [IDX_W-1:0]         idx_ticks_i,
  input  logic                     idx_last_i,
  output logic                     bit_valid_o,
  output logic                     bit_o,
  output logic                     rev_end_o,
  output logic [FLUX_W+FRAC+1:0]   dur_o
);
  localparam int     NOM_TICKS = 2 * SAMPLE_MHZ;
  localparam int     RW        = FLUX_W + FRAC + 2;
  localparam int     CW        = IDX_W + FRAC + 2;
  localparam int     ZW        = $clog2(SYNC_ZEROS + 2);
  localparam longint NOMQ      = longint'(NOM_TICKS) << FRAC;

  fbp_state_e st_q;
  logic signed [RW-1:0] per_q, res_q, dur_q;
  logic signed [CW-1:0] cd_q;
  logic [ZW-1:0]        zeros_q;
  logic                 last_q, pend_q, bv_q, bit_q, rev_q;

  logic signed [RW-1:0] acc_sum, half, rem, per_nx, keep, cut;
  logic signed [CW-1:0] cd_dec, idx_q8;
  logic                 oos;

  always_comb begin
    acc_sum = res_q + $signed({2'b00, flux_ticks_i, {FRAC{1'b0}}});
    half    = per_q >>> 1;
    rem     = res_q - per_q;
    cd_dec  = cd_q - CW'(per_q);
    idx_q8  = $signed({2'b00, idx_ticks_i, {FRAC{1'b0}}});
    oos     = zeros_q > ZW'(SYNC_ZEROS);
  end

  fbp_period_adj #(.W(RW), .NOM_TICKS(NOM_TICKS), .FRAC(FRAC)) u_per (
    .per_i (per_q),
    .rem_i (rem),
    .oos_i (oos),
    .per_o (per_nx)
  );

  fbp_phase_trim #(.W(RW)) u_phase (
    .rem_i  (rem),
    .keep_o (keep),
    .cut_o  (cut)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDX;
      per_q   <= RW'(NOMQ);
      res_q   <= '0;
      cd_q    <= '0;
      zeros_q <= '0;
      last_q  <= 1'b0;
      pend_q  <= 1'b0;
      bv_q    <= 1'b0;
      bit_q   <= 1'b0;
      rev_q   <= 1'b0;
      dur_q   <= '0;
    end else begin
      bv_q  <= 1'b0;
      rev_q <= 1'b0;
      unique case (st_q)
        ST_IDX: if (idx_valid_i) begin
          cd_q   <= idx_q8;
          last_q <= idx_last_i;
          st_q   <= pend_q ? ST_EMIT : ST_ACC;
        end
        ST_ACC: if (flux_valid_i) begin
          res_q <= acc_sum;
          if (acc_sum >= half) begin
            zeros_q <= '0;
            st_q    <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (!pend_q && cd_dec < 0) begin
            // boundary: strobe, then hold this cell for the next revolution
            rev_q  <= 1'b1;
            pend_q <= 1'b1;
            st_q   <= last_q ? ST_DONE : ST_IDX;
          end else begin
            pend_q <= 1'b0;
            if (!pend_q) cd_q <= cd_dec;
            bv_q <= 1'b1;
            if (rem >= half) begin
              bit_q <= 1'b0;
              dur_q <= per_q;
              res_q <= rem;
              if (zeros_q != '1) zeros_q <= zeros_q + 1'b1;
            end else begin
              bit_q <= 1'b1;
              dur_q <= per_q + cut;
              res_q <= keep;
              per_q <= per_nx;
              st_q  <= ST_ACC;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign idx_ready_o  = (st_q == ST_IDX);
  assign flux_ready_o = (st_q == ST_ACC);
  assign bit_valid_o  = bv_q;
  assign bit_o        = bit_q;
  assign rev_end_o    = rev_q;
  assign dur_o        = dur_q;
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
  parameter int SAMPLE_MHZ = 24,
  parameter int FRAC       = 8,
  parameter int RW         = 26
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          flux_ready_o,
  input logic          idx_ready_o,
  input logic          bit_valid_o,
  input logic          bit_o,
  input logic          rev_end_o,
  input logic [RW-1:0] dur_o
);
  localparam longint NOMQ = longint'(2 * SAMPLE_MHZ) << FRAC;
  localparam longint MINQ = NOMQ - NOMQ / 10;
  localparam longint MAXQ = NOMQ + NOMQ / 10;

  a_r1_one_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flux_ready_o && idx_ready_o));
  a_r3_stall_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !bit_o) |-> !flux_ready_o);
  a_r7_zero_dur_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !bit_o) |-> (longint'(dur_o) >= MINQ && longint'(dur_o) <= MAXQ));
  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_valid_o && rev_end_o));
  a_r11_gap_after_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && bit_o) |=> !bit_valid_o);
  a_r9_gap_after_rev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_end_o |=> (!bit_valid_o && !rev_end_o));
endmodule

bind flux_bitcell_pll fbp_checker #(
  .SAMPLE_MHZ (SAMPLE_MHZ),
  .FRAC       (FRAC),
  .RW         (FLUX_W + FRAC + 2)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flux_ready_o (flux_ready_o),
  .idx_ready_o  (idx_ready_o),
  .bit_valid_o  (bit_valid_o),
  .bit_o        (bit_o),
  .rev_end_o    (rev_end_o),
  .dur_o        (dur_o)
);

// File: tb/sim_flux_bitcell_pll.sv
module sim_flux_bitcell_pll;
  localparam int     FRAC   = 8;
  localparam int     FLUX_W = 16;
  localparam int     IDX_W  = 24;
  localparam int     RW     = FLUX_W + FRAC + 2;
  localparam longint NOMQ   = 48 * 256;
  localparam longint MINQ   = NOMQ - NOMQ / 10;
  localparam longint MAXQ   = NOMQ + NOMQ / 10;
  localparam int     NV     = 10;
  // {interval ticks, expected cells near nominal}
  localparam logic [23:0] TBL [NV] = '{
    {16'd96, 8'd2}, {16'd144, 8'd3}, {16'd100, 8'd2}, {16'd46, 8'd1}, {16'd150, 8'd3},
    {16'd192, 8'd4}, {16'd94, 8'd2}, {16'd50, 8'd1}, {16'd140, 8'd3}, {16'd98, 8'd2}};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic flux_valid = 1'b0, idx_valid = 1'b0, idx_last = 1'b0;
  logic [FLUX_W-1:0] flux_ticks = '0;
  logic [IDX_W-1:0]  idx_ticks = '0;
  logic flux_ready, idx_ready, bit_valid, bit_v, rev_end;
  logic [RW-1:0] dur;

  flux_bitcell_pll u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .flux_valid_i(flux_valid), .flux_ready_o(flux_ready), .flux_ticks_i(flux_ticks),
    .idx_valid_i(idx_valid), .idx_ready_o(idx_ready), .idx_ticks_i(idx_ticks),
    .idx_last_i(idx_last),
    .bit_valid_o(bit_valid), .bit_o(bit_v), .rev_end_o(rev_end), .dur_o(dur));

  always #5 clk = ~clk;

  int errs = 0, checks = 0;
  longint cyc = 0;
  bit wd_hit = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  longint idx_list [8];
  int n_idx = 0, dk = 0, mk = 0;
  int exp_k [2048]; longint exp_d [2048]; int exp_n = 0;
  int got_k [2048]; longint got_d [2048]; int got_n = 0;
  longint m_per, m_res, m_cd;
  bit m_last, m_done;

  always @(negedge clk) if (rst_ni && got_n < 2048) begin
    if (bit_valid) begin got_k[got_n] = int'(bit_v); got_d[got_n] = longint'(dur); got_n++; end
    if (rev_end)   begin got_k[got_n] = 2; got_d[got_n] = 0; got_n++; end
  end

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic longint s5(longint v); return (v >>> 5) + (v >>> 6) + (v >>> 8); endfunction
  function automatic longint p4(longint v);
    return (v >>> 2) + (v >>> 3) + (v >>> 6) + (v >>> 7);
  endfunction

  task automatic push(int k, longint d); exp_k[exp_n] = k; exp_d[exp_n] = d; exp_n++; endtask

  task automatic model_load();
    m_cd = idx_list[mk] << 8; m_last = (mk == n_idx - 1); mk++;
  endtask

  task automatic model_flux(longint x);
    longint rn, np, nr;
    int z;
    if (m_done) return;
    m_res += x << 8;
    if (m_res < (m_per >>> 1)) return;
    z = 0;
    forever begin
      m_cd -= m_per;
      if (m_cd < 0) begin
        push(2, 0);
        if (m_last) begin m_done = 1'b1; return; end
        model_load();
      end
      rn = m_res - m_per;
      if (rn >= (m_per >>> 1)) begin
        push(0, m_per); m_res = rn; z++;
      end else begin
        np = (z <= 3) ? m_per + s5(rn) : m_per + s5(NOMQ - m_per);
        if (np < MINQ) np = MINQ;
        if (np > MAXQ) np = MAXQ;
        nr = p4(rn);
        push(1, m_per + rn - nr);
        m_per = np; m_res = nr;
        break;
      end
    end
  endtask

  task automatic present_idx();
    if (dk < n_idx) begin
      idx_valid = 1'b1; idx_ticks = IDX_W'(idx_list[dk]); idx_last = (dk == n_idx - 1);
    end else begin
      idx_valid = 1'b0; idx_last = 1'b0;
    end
  endtask

  task automatic tick();
    bit fire;
    fire = rst_ni && idx_valid && idx_ready;
    @(negedge clk);
    if (fire) begin dk++; present_idx(); end
  endtask

  task automatic send_flux(int x);
    flux_valid = 1'b1; flux_ticks = FLUX_W'(x);
    while (!flux_ready && !wd_hit) tick();
    tick();
    flux_valid = 1'b0;
    model_flux(longint'(x));
  endtask

  task automatic start(bit check_reset);
    @(negedge clk);
    rst_ni = 1'b0; flux_valid = 1'b0; dk = 0; mk = 0; present_idx();
    repeat (3) @(negedge clk);
    if (check_reset) begin
      chk(idx_ready == 1'b1, "R1 idx_ready in reset", longint'(idx_ready), 1);
      chk(flux_ready == 1'b0, "R1 flux_ready in reset", longint'(flux_ready), 0);
      chk(bit_valid == 1'b0, "R1 bit_valid in reset", longint'(bit_valid), 0);
    end
    got_n = 0; exp_n = 0;
    m_per = NOMQ; m_res = 0; m_done = 1'b0;
    model_load();
    rst_ni = 1'b1;
  endtask

  task automatic drain(); repeat (60) tick(); endtask

  task automatic compare_all(string req);
    chk(got_n == exp_n, req, longint'(got_n), longint'(exp_n));
    for (int i = 0; i < got_n && i < exp_n; i++) begin
      chk(got_k[i] == exp_k[i], req, longint'(got_k[i]), longint'(exp_k[i]));
      chk(got_d[i] == exp_d[i], req, got_d[i], exp_d[i]);
    end
  endtask

  function automatic longint first_zero_dur();
    for (int i = 0; i < got_n; i++) if (got_k[i] == 0) return got_d[i];
    return -1;
  endfunction

  initial begin
    wait (cyc == 150000);
    wd_hit = 1'b1; errs++; checks++;
    $display("FAIL watchdog: got %0d expected 0", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cells;
    // vector table, nominal-rate intervals
    idx_list[0] = 2000000; n_idx = 1;
    start(1'b1);
    tick(); tick();
    chk(flux_ready == 1'b1, "R1 flux_ready after index", longint'(flux_ready), 1);
    cells = 0;
    for (int v = 0; v < NV; v++) begin
      send_flux(int'(TBL[v][23:8]));
      cells += int'(TBL[v][7:0]);
    end
    drain();
    compare_all("R3,R4,R5,R8 table");
    begin
      int n = 0;
      for (int i = 0; i < got_n; i++) if (got_k[i] < 2) n++;
      chk(n == cells, "R3 cell count", longint'(n), longint'(cells));
    end

    // long gap: out-of-sync branch
    start(1'b0);
    send_flux(96); send_flux(400); send_flux(96); send_flux(150); send_flux(96);
    drain();
    compare_all("R6 long gap");

    // half-period threshold
    start(1'b0);
    send_flux(10); send_flux(10); repeat (5) tick();
    chk(got_n == 0, "R2 below half", longint'(got_n), 0);
    send_flux(4); drain();
    chk(got_n == 1, "R2 at half", longint'(got_n), 1);
    chk(got_k[0] == 1, "R3 single one", longint'(got_k[0]), 1);
    compare_all("R2,R8 threshold");

    // low clamp
    start(1'b0);
    for (int i = 0; i < 60; i++) send_flux(40);
    drain(); got_n = 0; exp_n = 0;
    send_flux(200); drain();
    chk(first_zero_dur() == MINQ, "R7 low clamp", first_zero_dur(), MINQ);
    compare_all("R7 low");

    // high clamp
    start(1'b0);
    for (int i = 0; i < 60; i++) send_flux(56);
    drain(); got_n = 0; exp_n = 0;
    send_flux(200); drain();
    chk(first_zero_dur() == MAXQ, "R7 high clamp", first_zero_dur(), MAXQ);
    compare_all("R7 high");

    // short revolutions, then stop
    idx_list[0] = 600; idx_list[1] = 500; idx_list[2] = 400; n_idx = 3;
    start(1'b0);
    for (int i = 0; i < 30; i++) if (!m_done) send_flux(96);
    drain();
    compare_all("R9 revolutions");
    begin
      int r = 0;
      for (int i = 0; i < got_n; i++) if (got_k[i] == 2) r++;
      chk(r == 3, "R9 strobe count", longint'(r), 3);
    end
    chk(got_n > 0 && got_k[got_n-1] == 2, "R10 nothing after last strobe",
        got_n > 0 ? longint'(got_k[got_n-1]) : -1, 2);
    chk(flux_ready == 1'b0, "R10 stopped", longint'(flux_ready), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule